// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the register front end of a three-channel interval timer. A host reaches it through four byte-wide locations: three channel data locations and one command location. Control words written to the command location set each channel's counting mode, byte access format and decimal flag. They can also freeze a channel's current count for readout, or capture a channel's configuration as a status byte. The down-counters and output waveform generators sit outside this block. It feeds them a reload value with a load strobe, an effective mode, a decimal flag and a configuration strobe, and it takes back each channel's live count.

Data writes are gathered into 16-bit reload values according to the channel's format. Each channel keeps a write-side toggle and a read-side toggle, so in two-byte format the low byte always goes first. A reload value is handed over only once the last byte the format needs has arrived. Reads return, in priority order, a pending status byte, then a frozen count, then the live count, each in the channel's byte format.

Top module: `itmr_regif`

## Requirements
- R1: After reset every channel reports mode 0 and binary counting, uses the two-byte format (low byte first) and holds no frozen count or status. No load or configuration strobe is active.
- R2: A command write (address 3) whose bits 7:6 are 0, 1 or 2 and whose bits 5:4 are not 00 configures that channel. It stores bits 5:4 as the format, bits 3:1 as the mode and bit 0 as the decimal flag, and it resets both byte toggles. `ch_cfg_wr` for that channel is high for exactly the cycle after the write, and `ch_mode`/`ch_bcd` change only together with that strobe.
- R3: In format 01 (low byte only), a data write of byte d gives reload value {0x00, d} and a one-cycle `ch_load` pulse in the cycle after the write.
- R4: In format 10 (high byte only), a data write of byte d gives reload value {d, 0x00} and a one-cycle `ch_load` pulse in the cycle after the write.
- R5: In format 11, the first data write is held without a load. The second data write produces reload {second, first} with a `ch_load` pulse. A reload of 0x0000, which the counter takes as 65536, is passed on unchanged. `ch_reload` changes only together with `ch_load`.
- R6: Mode codes 6 and 7 are kept as written (they appear in the status byte), but `ch_mode` reports them as mode 0.
- R7: A command write with format bits 00 freezes the channel's count as it stands at that write, without changing the channel's configuration. Reads then return the frozen bytes in the channel's format, whatever the live count does.
- R8: While a frozen count has not been fully read out, further freeze commands for that channel are ignored. After the final byte has been read, reads return the live count again.
- R9: Without a frozen count, reads return the live count: the low byte in format 01, the high byte in format 10, and alternately low then high in format 11. Each channel's read toggle is independent of the others.
- R10: A command write with bits 7:6 = 11 captures a status byte for every channel i whose bit i+1 is set (0xC2 selects channel 0). The status byte is {2'b00, format, mode, decimal}. The next read of that channel returns it, once, without moving the read toggle.
- R11: `bus_rdata` is 0 when the command address is read.
- R12: A control word written between the two bytes of a format-11 load discards the first byte, so the next data byte is taken as the low byte again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe, one cycle per byte |
| bus_rd | input | 1 | Host read strobe, one cycle per byte |
| bus_addr | input | 2 | 0..2 channel data, 3 command |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid while bus_rd is high |
| ch_count | input | 16*NUM_CH | Live count of each channel |
| ch_load | output | NUM_CH | One-cycle strobe: new reload value ready |
| ch_reload | output | 16*NUM_CH | Reload value of each channel |
| ch_mode | output | 3*NUM_CH | Effective operating mode of each channel |
| ch_bcd | output | NUM_CH | Decimal counting flag of each channel |
| ch_cfg_wr | output | NUM_CH | One-cycle strobe: channel was reconfigured |

## Verification
Every effect of a write (`ch_load`, `ch_reload`, `ch_cfg_wr`, `ch_mode`, `ch_bcd`) is registered, so it appears in the cycle after the clock edge that takes the write. The bench therefore checks these at the falling edge that follows that edge, and checks that strobes have dropped one cycle later. Read data is combinational and due in the same cycle as `bus_rd`, so the bench samples it shortly after driving the read and before the edge that commits the read's toggle and latch side effects. Freeze commands are checked against a live count that the bench changes between the freeze and the reads.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    localparam int BYTE_W    = 8;
    localparam int CNT_W     = 16;
    localparam int MODE_W    = 3;
    localparam int CH_ADDR_W = 2;
    localparam logic [CH_ADDR_W-1:0] CMD_ADDR = 2'd3;
    localparam logic [1:0] SEL_READBACK = 2'b11;
    localparam logic [MODE_W-1:0] MODE_LAST_DEFINED = 3'd5;

    typedef enum logic [1:0] {
        FMT_FREEZE = 2'b00,
        FMT_LO     = 2'b01,
        FMT_HI     = 2'b10,
        FMT_LOHI   = 2'b11
    } fmt_e;

    typedef struct packed {
        logic [1:0]        sel;
        fmt_e              fmt;
        logic [MODE_W-1:0] mode;
        logic              bcd;
    } ctrl_t;

    function automatic logic [MODE_W-1:0] eff_mode(input logic [MODE_W-1:0] m);
        return (m > MODE_LAST_DEFINED) ? '0 : m;
    endfunction

    function automatic logic [BYTE_W-1:0] status_byte(input fmt_e f,
                                                      input logic [MODE_W-1:0] m,
                                                      input logic b);
        return {2'b00, f, m, b};
    endfunction

endpackage

// File: rtl/itmr_cmd_dec.sv
module itmr_cmd_dec
    import itmr_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [CH_ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0]    bus_wdata,
    output logic [NUM_CH-1:0]    cw_wr,
    output logic [NUM_CH-1:0]    freeze_cmd,
    output logic [NUM_CH-1:0]    stat_cmd,
    output logic [NUM_CH-1:0]    data_wr,
    output logic [NUM_CH-1:0]    data_rd,
    output fmt_e                 cw_fmt,
    output logic [MODE_W-1:0]    cw_mode,
    output logic                 cw_bcd
);
    ctrl_t cw;
    logic  is_cmd;

    assign cw      = ctrl_t'(bus_wdata);
    assign is_cmd  = bus_wr && (bus_addr == CMD_ADDR);
    assign cw_fmt  = cw.fmt;
    assign cw_mode = cw.mode;
    assign cw_bcd  = cw.bcd;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        assign hit           = is_cmd && (cw.sel == CH_ADDR_W'(i));
        assign cw_wr[i]      = hit && (cw.fmt != FMT_FREEZE);
        assign freeze_cmd[i] = hit && (cw.fmt == FMT_FREEZE);
        assign stat_cmd[i]   = is_cmd && (cw.sel == SEL_READBACK) && bus_wdata[i+1];
        assign data_wr[i]    = bus_wr && (bus_addr == CH_ADDR_W'(i));
        assign data_rd[i]    = bus_rd && (bus_addr == CH_ADDR_W'(i));
    end
endmodule

// File: rtl/itmr_chan_regs.sv
module itmr_chan_regs
    import itmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cw_wr,
    input  logic              freeze_cmd,
    input  logic              stat_cmd,
    input  logic              data_wr,
    input  logic              data_rd,
    input  fmt_e              cw_fmt,
    input  logic [MODE_W-1:0] cw_mode,
    input  logic              cw_bcd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt_in,
    output logic [BYTE_W-1:0] rdata,
    output logic              load,
    output logic [CNT_W-1:0]  reload,
    output logic [MODE_W-1:0] mode_eff,
    output logic              bcd,
    output logic              cfg_wr
);
    fmt_e              fmt_q;
    logic [MODE_W-1:0] mode_q;
    logic              wr_hi, rd_hi;
    logic [BYTE_W-1:0] low_q;
    logic              frz_v, stat_v;
    logic [CNT_W-1:0]  frz_q;
    logic [BYTE_W-1:0] stat_q;
    logic [CNT_W-1:0]  src;

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_q  <= FMT_LOHI;
            mode_q <= '0;
            bcd    <= 1'b0;
            wr_hi  <= 1'b0;
            rd_hi  <= 1'b0;
            low_q  <= '0;
            frz_v  <= 1'b0;
            frz_q  <= '0;
            stat_v <= 1'b0;
            stat_q <= '0;
            load   <= 1'b0;
            reload <= '0;
            cfg_wr <= 1'b0;
        end else begin
            load   <= 1'b0;
            cfg_wr <= 1'b0;
            if (cw_wr) begin
                fmt_q  <= cw_fmt;
                mode_q <= cw_mode;
                bcd    <= cw_bcd;
                wr_hi  <= 1'b0;
                rd_hi  <= 1'b0;
                frz_v  <= 1'b0;
                cfg_wr <= 1'b1;
            end else if (freeze_cmd && !frz_v) begin
                frz_v <= 1'b1;
                frz_q <= cnt_in;
            end
            if (stat_cmd && !stat_v) begin
                stat_v <= 1'b1;
                stat_q <= status_byte(fmt_q, mode_q, bcd);
            end
            if (data_wr) begin
                case (fmt_q)
                    FMT_LO: begin
                        reload <= {{(CNT_W-BYTE_W){1'b0}}, wdata};
                        load   <= 1'b1;
                    end
                    FMT_HI: begin
                        reload <= {wdata, {(CNT_W-BYTE_W){1'b0}}};
                        load   <= 1'b1;
                    end
                    default: begin
                        if (!wr_hi) begin
                            low_q <= wdata;
                            wr_hi <= 1'b1;
                        end else begin
                            reload <= {wdata, low_q};
                            load   <= 1'b1;
                            wr_hi  <= 1'b0;
                        end
                    end
                endcase
            end
            if (data_rd) begin
                if (stat_v) begin
                    stat_v <= 1'b0;
                end else if (fmt_q == FMT_LO || fmt_q == FMT_HI) begin
                    frz_v <= 1'b0;
                end else begin
                    rd_hi <= ~rd_hi;
                    if (rd_hi) frz_v <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        src = frz_v ? frz_q : cnt_in;
        if (stat_v) begin
            rdata = stat_q;
        end else begin
            case (fmt_q)
                FMT_LO:  rdata = src[BYTE_W-1:0];
                FMT_HI:  rdata = src[CNT_W-1 -: BYTE_W];
                default: rdata = rd_hi ? src[CNT_W-1 -: BYTE_W] : src[BYTE_W-1:0];
            endcase
        end
    end

    assign mode_eff = eff_mode(mode_q);
endmodule

// File: rtl/itmr_regif.sv
module itmr_regif
    import itmr_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [CH_ADDR_W-1:0]       bus_addr,
    input  logic [BYTE_W-1:0]          bus_wdata,
    output logic [BYTE_W-1:0]          bus_rdata,
    input  logic [NUM_CH*CNT_W-1:0]    ch_count,
    output logic [NUM_CH-1:0]          ch_load,
    output logic [NUM_CH*CNT_W-1:0]    ch_reload,
    output logic [NUM_CH*MODE_W-1:0]   ch_mode,
    output logic [NUM_CH-1:0]          ch_bcd,
    output logic [NUM_CH-1:0]          ch_cfg_wr
);
    logic [NUM_CH-1:0] cw_wr, freeze_cmd, stat_cmd, data_wr, data_rd;
    fmt_e              cw_fmt;
    logic [MODE_W-1:0] cw_mode;
    logic              cw_bcd;
    logic [BYTE_W-1:0] ch_rdata [NUM_CH];

    itmr_cmd_dec #(.NUM_CH(NUM_CH)) u_dec (
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .cw_wr      (cw_wr),
        .freeze_cmd (freeze_cmd),
        .stat_cmd   (stat_cmd),
        .data_wr    (data_wr),
        .data_rd    (data_rd),
        .cw_fmt     (cw_fmt),
        .cw_mode    (cw_mode),
        .cw_bcd     (cw_bcd)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        itmr_chan_regs u_chan (
            .clk        (clk),
            .rst        (rst),
            .cw_wr      (cw_wr[i]),
            .freeze_cmd (freeze_cmd[i]),
            .stat_cmd   (stat_cmd[i]),
            .data_wr    (data_wr[i]),
            .data_rd    (data_rd[i]),
            .cw_fmt     (cw_fmt),
            .cw_mode    (cw_mode),
            .cw_bcd     (cw_bcd),
            .wdata      (bus_wdata),
            .cnt_in     (ch_count[i*CNT_W +: CNT_W]),
            .rdata      (ch_rdata[i]),
            .load       (ch_load[i]),
            .reload     (ch_reload[i*CNT_W +: CNT_W]),
            .mode_eff   (ch_mode[i*MODE_W +: MODE_W]),
            .bcd        (ch_bcd[i]),
            .cfg_wr     (ch_cfg_wr[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_rd && bus_addr == CH_ADDR_W'(i)) bus_rdata = ch_rdata[i];
        end
    end
endmodule

// File: rtl/itmr_regif_chk.sv
module itmr_regif_chk
    import itmr_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     bus_wr,
    input logic [CH_ADDR_W-1:0]     bus_addr,
    input logic [3:0]               cw_hi,
    input logic [NUM_CH-1:0]        ch_load,
    input logic [NUM_CH*CNT_W-1:0]  ch_reload,
    input logic [NUM_CH*MODE_W-1:0] ch_mode,
    input logic [NUM_CH-1:0]        ch_cfg_wr
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // R3: a load strobe always follows a data write to the same channel
        assert_load_src_R3: assert property (@(posedge clk) disable iff (rst)
            ch_load[i] |-> $past(bus_wr && bus_addr == CH_ADDR_W'(i)));

        // R2: a configuration strobe follows a non-freeze control word for this channel
        assert_cfg_src_R2: assert property (@(posedge clk) disable iff (rst)
            ch_cfg_wr[i] |-> $past(bus_wr && bus_addr == CMD_ADDR &&
                                   cw_hi[3:2] == 2'(i) && cw_hi[1:0] != 2'b00));

        // R2: mode moves only with the configuration strobe
        assert_mode_hold_R2: assert property (@(posedge clk) disable iff (rst)
            !ch_cfg_wr[i] |-> $stable(ch_mode[i*MODE_W +: MODE_W]));

        // R5: reload value moves only with the load strobe
        assert_reload_hold_R5: assert property (@(posedge clk) disable iff (rst)
            !ch_load[i] |-> $stable(ch_reload[i*CNT_W +: CNT_W]));

        // R6: the effective mode never shows an undefined code
        assert_mode_legal_R6: assert property (@(posedge clk) disable iff (rst)
            ch_mode[i*MODE_W +: MODE_W] <= MODE_LAST_DEFINED);

        // R2: a channel is never configured and loaded in the same cycle
        assert_cfg_load_excl_R2: assert property (@(posedge clk) disable iff (rst)
            !(ch_cfg_wr[i] && ch_load[i]));
    end
endmodule

bind itmr_regif itmr_regif_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .cw_hi     (bus_wdata[7:4]),
    .ch_load   (ch_load),
    .ch_reload (ch_reload),
    .ch_mode   (ch_mode),
    .ch_cfg_wr (ch_cfg_wr)
);

// File: tb/tb_itmr_regif.sv
module tb_itmr_regif;
    localparam int NCH = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]        bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic [15:0]       cnt0 = 16'h1234, cnt1 = 16'hABCD, cnt2 = 16'h5A3C;
    logic [NCH*16-1:0] ch_count;
    logic [NCH-1:0]    ch_load, ch_bcd, ch_cfg_wr;
    logic [NCH*16-1:0] ch_reload;
    logic [NCH*3-1:0]  ch_mode;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    assign ch_count = {cnt2, cnt1, cnt0};

    always #4 clk = ~clk;

    itmr_regif #(.NUM_CH(NCH)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ch_count(ch_count), .ch_load(ch_load), .ch_reload(ch_reload),
        .ch_mode(ch_mode), .ch_bcd(ch_bcd), .ch_cfg_wr(ch_cfg_wr)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // vector: {kind[1:0], req[3:0], addr[1:0], data[7:0], exp[15:0]}
    localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_CK = 2'd2;
    localparam int NV = 24;
    localparam logic [31:0] VEC [NV] = '{
        {K_WR, 4'd2,  2'd3, 8'h16, 16'h0000},  // R2 ch0 low-only, mode 3
        {K_WR, 4'd3,  2'd0, 8'h7F, 16'h0000},  // R3
        {K_CK, 4'd3,  2'd0, 8'h00, 16'h007F},  // R3
        {K_WR, 4'd2,  2'd3, 8'h64, 16'h0000},  // R2 ch1 high-only, mode 2
        {K_WR, 4'd4,  2'd1, 8'h9C, 16'h0000},  // R4
        {K_CK, 4'd4,  2'd1, 8'h00, 16'h9C00},  // R4
        {K_WR, 4'd2,  2'd3, 8'hB7, 16'h0000},  // R2 ch2 two-byte, mode 3, decimal
        {K_WR, 4'd5,  2'd2, 8'h34, 16'h0000},  // R5
        {K_WR, 4'd5,  2'd2, 8'h12, 16'h0000},  // R5
        {K_CK, 4'd5,  2'd2, 8'h00, 16'h1234},  // R5
        {K_RD, 4'd9,  2'd2, 8'h00, 16'h003C},  // R9 low first
        {K_RD, 4'd9,  2'd2, 8'h00, 16'h005A},  // R9 then high
        {K_RD, 4'd9,  2'd0, 8'h00, 16'h0034},  // R9 low-only
        {K_RD, 4'd9,  2'd1, 8'h00, 16'h00AB},  // R9 high-only
        {K_WR, 4'd10, 2'd3, 8'hC2, 16'h0000},  // R10 status of ch0
        {K_RD, 4'd10, 2'd0, 8'h00, 16'h0016},  // R10
        {K_RD, 4'd10, 2'd0, 8'h00, 16'h0034},  // R10 consumed once
        {K_WR, 4'd10, 2'd3, 8'hC8, 16'h0000},  // R10 status of ch2
        {K_RD, 4'd10, 2'd2, 8'h00, 16'h0037},  // R10
        {K_RD, 4'd10, 2'd2, 8'h00, 16'h003C},  // R10 toggle untouched
        {K_RD, 4'd11, 2'd3, 8'h00, 16'h0000},  // R11
        {K_WR, 4'd5,  2'd2, 8'h00, 16'h0000},  // R5 zero reload
        {K_WR, 4'd5,  2'd2, 8'h00, 16'h0000},  // R5
        {K_CK, 4'd5,  2'd2, 8'h00, 16'h0000}   // R5
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 mode", 16'(ch_mode), 16'h0);
        check("R1 bcd", 16'(ch_bcd), 16'h0);
        check("R1 load", 16'(ch_load), 16'h0);
        check("R1 cfg", 16'(ch_cfg_wr), 16'h0);
        rd(2'd0, v); check("R1 lo first", 16'(v), 16'h0034);
        rd(2'd0, v); check("R1 hi second", 16'(v), 16'h0012);

        for (int k = 0; k < NV; k++) begin
            logic [1:0] kind, a;
            logic [3:0] req;
            logic [7:0] d;
            logic [15:0] e;
            string tag;
            {kind, req, a, d, e} = VEC[k];
            tag = $sformatf("R%0d vector %0d", req, k);
            case (kind)
                K_WR: wr(a, d);
                K_RD: begin rd(a, v); check(tag, 16'(v), e); end
                default: begin
                    check({tag, " load"}, 16'(ch_load[a]), 16'h1);
                    check({tag, " reload"}, ch_reload[a*16 +: 16], e);
                end
            endcase
        end

        // R2 channel 2 configuration outputs
        check("R2 ch2 mode", 16'(ch_mode[8:6]), 16'h3);
        check("R2 ch2 bcd", 16'(ch_bcd[2]), 16'h1);

        // R6 undefined mode 6 on ch0, low-only
        wr(2'd3, 8'h1C);
        check("R6 cfg strobe", 16'(ch_cfg_wr), 16'h1);
        check("R6 eff mode", 16'(ch_mode[2:0]), 16'h0);
        @(negedge clk);
        check("R2 cfg one cycle", 16'(ch_cfg_wr), 16'h0);
        wr(2'd3, 8'hC2);
        rd(2'd0, v); check("R6 raw status", 16'(v), 16'h001C);

        // R5 / R12 two-byte ordering
        wr(2'd3, 8'h30);
        wr(2'd0, 8'h11);
        check("R5 no load first byte", 16'(ch_load[0]), 16'h0);
        wr(2'd3, 8'h30);
        wr(2'd0, 8'h22);
        check("R12 no load after rewrite", 16'(ch_load[0]), 16'h0);
        wr(2'd0, 8'h33);
        check("R12 load", 16'(ch_load[0]), 16'h1);
        check("R12 reload", ch_reload[15:0], 16'h3322);

        // R7 / R8 freeze
        cnt0 = 16'hBEEF;
        wr(2'd3, 8'h00);
        check("R7 no reconfig", 16'(ch_cfg_wr), 16'h0);
        cnt0 = 16'h1111;
        rd(2'd0, v); check("R7 frozen lo", 16'(v), 16'h00EF);
        wr(2'd3, 8'h00);
        rd(2'd0, v); check("R8 second freeze ignored", 16'(v), 16'h00BE);
        wr(2'd3, 8'h00);
        cnt0 = 16'h2222;
        rd(2'd0, v); check("R7 new freeze lo", 16'(v), 16'h0011);
        rd(2'd0, v); check("R7 new freeze hi", 16'(v), 16'h0011);
        rd(2'd0, v); check("R8 live after readout", 16'(v), 16'h0022);

        // R9 independent read toggles
        cnt0 = 16'h4321;
        wr(2'd3, 8'h30);
        wr(2'd3, 8'hB6);
        rd(2'd2, v); check("R9 ch2 lo", 16'(v), 16'h003C);
        rd(2'd0, v); check("R9 ch0 lo", 16'(v), 16'h0021);
        rd(2'd2, v); check("R9 ch2 hi", 16'(v), 16'h005A);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule